// File: doc/BRIEF.md
# Burst Address Sequencer (Two-Bit, Linear or Interleaved)

This block produces the address stream for a four-beat burst into a synchronous memory. A start address is captured on a load cycle. On each later enabled cycle that asks to advance, the two lowest address bits step to the next beat of the burst. The upper bits keep the captured value for the whole burst. A mode input chooses the beat order. In linear order the low bits count up and wrap. In interleaved order the low bits are the start value XOR-ed with the beat number.

A stall input freezes the whole block. While it is high, every register keeps its value and the address and control inputs are ignored. A small state machine tracks the beat. Its states are EMPTY (nothing loaded since reset), BEAT0, BEAT1, BEAT2 and BEAT3. Its transitions are:
- LOAD: from any state to BEAT0.
- STEP: BEAT0 to BEAT1, BEAT1 to BEAT2, BEAT2 to BEAT3.
- WRAP: BEAT3 to BEAT0.
- HOLD: no state change, taken when stalled, or when asked to advance in EMPTY.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0, `beat_o` is 0 and `valid_o` is 0 (state EMPTY).
- R2: In state EMPTY, an enabled cycle with `advance_i`=1 changes nothing: `addr_o`, `beat_o` and `valid_o` stay at their reset values.
- R3: An enabled cycle (`stall_i`=0) with `advance_i`=0 loads `addr_i` from any state. From the next cycle, `addr_o` equals that `addr_i` (under either mode), `beat_o` is 0 and `valid_o` is 1.
- R4: When `valid_o`=1, an enabled cycle with `advance_i`=1 sets `beat_o` to the old `beat_o`+1 modulo 4, so the burst wraps from beat 3 back to beat 0.
- R5: With `mode_i`=0 (linear), `addr_o[1:0]` = (s + `beat_o`) mod 4, where s is the loaded value of bits [1:0]. From s=1 this gives 1,2,3,0.
- R6: With `mode_i`=1 (interleaved), `addr_o[1:0]` = s XOR `beat_o`. From s=1 this gives 1,0,3,2.
- R7: Advancing never changes `addr_o[ADDR_W-1:2]`. These bits keep the loaded value through any number of wraps.
- R8: While `stall_i`=1, `beat_o`, `valid_o` and the loaded address hold, and `addr_i` and `advance_i` have no effect.
- R9: `mode_i` acts combinationally on the current beat. Changing it alters `addr_o[1:0]` in the same cycle and does not change `beat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | 1 freezes all registers |
| advance_i | input | 1 | 1 = step to next beat, 0 = load `addr_i` |
| mode_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Beat number within the burst |
| valid_o | output | 1 | An address has been loaded since reset |

## Verification
The hardest case to reach is a stall that arrives in the middle of a burst that has already wrapped, while `addr_i` and `advance_i` are changing. The block must not drift, and the upper bits must not pick up the new input. The stimulus loads a start address and advances past beat 3 into a second pass. It then raises `stall_i` while it drives a different address with a load request, and afterwards confirms that the sequence resumes from the held beat. A second hard case is a load that lands at beat 2: the new start address must be accepted at once and the beat must go back to zero.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_EMPTY = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } burst_state_t;
endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    output logic [BEAT_W-1:0] beat,
    output logic              valid
);
    burst_state_t state_q, state_d;

    // State register: frozen whenever the block is stalled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else if (en)
            state_q <= state_d;
    end

    // Next-state logic: LOAD from anywhere, otherwise STEP or WRAP.
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else begin
            unique case (state_q)
                ST_EMPTY: state_d = ST_EMPTY;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_EMPTY;
            endcase
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        beat  = '0;
        valid = 1'b1;
        unique case (state_q)
            ST_EMPTY: valid = 1'b0;
            ST_BEAT0: beat  = 2'd0;
            ST_BEAT1: beat  = 2'd1;
            ST_BEAT2: beat  = 2'd2;
            ST_BEAT3: beat  = 2'd3;
            default:  valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base <= '0;
        else if (capture)
            base <= addr_in;
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_addr_pkg::*;
(
    input  logic              interleave,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] xor_low;

    assign lin_low = start + beat;
    assign xor_low = start ^ beat;
    assign low     = interleave ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              advance_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              valid_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic              en;
    logic              load;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] low;

    assign en   = !stall_i;
    assign load = !advance_i;

    burst_beat_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .load  (load),
        .beat  (beat_o),
        .valid (valid_o)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (en && load),
        .addr_in (addr_i),
        .base    (base)
    );

    burst_order_map u_map (
        .interleave (mode_i),
        .start      (base[BEAT_W-1:0]),
        .beat       (beat_o),
        .low        (low)
    );

    generate
        if (UPPER_W > 0) begin : g_upper
            assign addr_o = {base[ADDR_W-1:BEAT_W], low};
        end else begin : g_low_only
            assign addr_o = low;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall_i,
    input logic              advance_i,
    input logic              mode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        beat_o,
    input logic              valid_o
);
    // R1
    always_comb begin
        if (!rst_n) begin
            reset_state_chk: assert (addr_o == '0 && beat_o == 2'd0 && !valid_o);
        end
    end

    // R2
    empty_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && advance_i && !valid_o) |=> (!valid_o && beat_o == 2'd0 && addr_o == '0));

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !advance_i) |=> (addr_o == $past(addr_i) && beat_o == 2'd0 && valid_o));

    // R4
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && advance_i && valid_o) |=> (beat_o == $past(beat_o) + 2'd1));

    // R7
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && advance_i) |=> $stable(addr_o[ADDR_W-1:2]));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(beat_o) && $stable(valid_o) && $stable(addr_o[ADDR_W-1:2])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_i   (stall_i),
    .advance_i (advance_i),
    .mode_i    (mode_i),
    .addr_i    (addr_i),
    .addr_o    (addr_o),
    .beat_o    (beat_o),
    .valid_o   (valid_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall_i = 1'b0;
    logic          advance_i = 1'b1;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;
    logic          valid_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_i   (stall_i),
        .advance_i (advance_i),
        .mode_i    (mode_i),
        .addr_i    (addr_i),
        .addr_o    (addr_o),
        .beat_o    (beat_o),
        .valid_o   (valid_o)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] start, input logic [1:0] b, input logic m);
        logic [1:0] lo;
        lo = m ? (start[1:0] ^ b) : (start[1:0] + b);
        return {start[AW-1:2], lo};
    endfunction

    // One clock: inputs are set 1 ns after a rising edge, outputs read 1 ns after the next.
    task automatic cyc(input logic st, input logic adv, input logic [AW-1:0] a);
        stall_i   = st;
        advance_i = adv;
        addr_i    = a;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk(addr_o == '0, "R1 addr", addr_o, '0);
        chk(beat_o == 2'd0 && !valid_o, "R1 beat/valid", {beat_o, valid_o}, '0);
    endtask

    task automatic t_empty_advance;
        cyc(1'b0, 1'b1, 20'hABCDE);
        cyc(1'b0, 1'b1, 20'h12345);
        chk(addr_o == '0 && !valid_o && beat_o == 2'd0, "R2", addr_o, '0);
    endtask

    task automatic t_burst(input logic m, input logic [AW-1:0] start, input string req);
        mode_i = m;
        cyc(1'b0, 1'b0, start);
        chk(addr_o == start && beat_o == 2'd0 && valid_o, "R3 load", addr_o, start);
        for (int k = 1; k <= 6; k++) begin
            cyc(1'b0, 1'b1, ~start);
            chk(beat_o == 2'(k), "R4 beat", AW'(beat_o), AW'(2'(k)));
            chk(addr_o == expect_addr(start, 2'(k), m), req, addr_o, expect_addr(start, 2'(k), m));
            chk(addr_o[AW-1:2] == start[AW-1:2], "R7 upper", addr_o, start);
        end
    endtask

    task automatic t_stall;
        logic [AW-1:0] start = 20'h5A5A6;
        mode_i = 1'b0;
        cyc(1'b0, 1'b0, start);
        for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, '0);
        // beat is now 1 after one wrap
        cyc(1'b1, 1'b0, 20'hFFFFF);
        cyc(1'b1, 1'b1, 20'h00001);
        chk(beat_o == 2'd1, "R8 beat", AW'(beat_o), AW'(1));
        chk(addr_o == expect_addr(start, 2'd1, 1'b0), "R8 addr", addr_o, expect_addr(start, 2'd1, 1'b0));
        cyc(1'b0, 1'b1, 20'hFFFFF);
        chk(addr_o == expect_addr(start, 2'd2, 1'b0), "R8 resume", addr_o, expect_addr(start, 2'd2, 1'b0));
    endtask

    task automatic t_reload_mid;
        logic [AW-1:0] s2 = 20'h0F0F3;
        cyc(1'b0, 1'b0, s2);
        chk(addr_o == s2 && beat_o == 2'd0, "R3 reload mid-burst", addr_o, s2);
    endtask

    task automatic t_mode_live;
        logic [AW-1:0] s = 20'h33331;
        mode_i = 1'b0;
        cyc(1'b0, 1'b0, s);
        cyc(1'b0, 1'b1, s);
        cyc(1'b0, 1'b1, s);
        chk(addr_o[1:0] == 2'd3, "R9 linear", AW'(addr_o[1:0]), AW'(3));
        mode_i = 1'b1;
        #1;
        chk(addr_o[1:0] == 2'd3 && beat_o == 2'd2, "R9 interleaved", AW'(addr_o[1:0]), AW'(3));
        cyc(1'b0, 1'b1, s);
        chk(addr_o[1:0] == 2'd2, "R9 next", AW'(addr_o[1:0]), AW'(2));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #5;
        t_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_empty_advance();
        t_burst(1'b0, 20'h12341, "R5 linear");
        t_burst(1'b1, 20'hABCD1, "R6 interleaved");
        t_burst(1'b1, 20'h00002, "R6 interleaved s2");
        t_burst(1'b0, 20'hFFFFF, "R5 linear s3");
        t_stall();
        t_reload_mid();
        t_mode_live();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule